// File: doc/BRIEF.md
# Signed Multiply Unit with Condition Flags

This block is the multiply stage of a 16-bit processor datapath. It takes a register operand and a source operand, treats both as two's-complement numbers and forms their full signed product. The product is split over a register pair: the upper half is aimed at the named destination register and the lower half at the odd partner of that register. The block has no state. The results settle combinationally from the inputs.

The parity of the destination index decides which halves are written. An even index writes both registers of the pair. An odd index writes only the low half, and it goes back into that same odd register. Four condition flags are produced alongside the data. Carry flags a product that does not fit in a signed 16-bit value. Overflow is always clear.

A single issue input gates both write enables. Data and flags follow the operands whether or not a write is being issued.

Top module: `smul_flags_unit`

## Requirements
- R1: The 32-bit product equals the low 32 bits of the product of the two operands after each is sign-extended to 32 bits. The upper 16 bits of the product appear on `hi_wr_data` and the lower 16 bits appear on `lo_wr_data`.
- R2: `hi_wr_idx` equals `dst_idx`. `hi_wr_en` is 1 exactly when `mul_go` is 1 and `dst_idx` bit 0 is 0.
- R3: `lo_wr_idx` equals `dst_idx` with bit 0 forced to 1. `lo_wr_en` equals `mul_go`.
- R4: When `dst_idx` is odd, only the low half is written, and it goes to `dst_idx` itself. For example, index 7 gives `lo_wr_idx` = 7 and `hi_wr_en` = 0, while index 6 writes 6 (high) and 7 (low).
- R5: `flag_n` equals bit 31 of the product.
- R6: `flag_z` is 1 exactly when all 32 bits of the product are zero.
- R7: `flag_v` is always 0.
- R8: `flag_c` is 1 exactly when the signed product is below -32768 or above 32767. For example, 0x8000 times 0x8000 gives 0x40000000 with `flag_c` = 1, while 0x8000 times 1 gives -32768 with `flag_c` = 0.
- R9: While `mul_go` is 0, both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mul_go | input | 1 | Issue strobe; permits the register writes |
| src_reg | input | 16 | Register operand, two's complement |
| src_opd | input | 16 | Source operand, two's complement |
| dst_idx | input | 3 | Destination register index |
| hi_wr_en | output | 1 | Write enable for the upper-half port |
| hi_wr_idx | output | 3 | Register index for the upper half |
| hi_wr_data | output | 16 | Upper 16 bits of the product |
| lo_wr_en | output | 1 | Write enable for the lower-half port |
| lo_wr_idx | output | 3 | Register index for the lower half |
| lo_wr_data | output | 16 | Lower 16 bits of the product |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always clear |
| flag_c | output | 1 | Product exceeds the signed 16-bit range |

## Verification
The assertions are checked after the combinational logic has settled. They assume the inputs are fully known values, so every operand bit and every index bit is 0 or 1, and they relate the flags to the two data ports rather than to the operands. The bench always drives complete, defined values. It changes them only just after a clock edge and reads the outputs at the opposite edge. Its operand patterns come from fixed corner values and a deterministic shift-register sequence, so no unknown value ever reaches the block.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_M1   = 3'd3,
    DIG_M2   = 3'd4
  } booth_dig_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  // radix-4 recoding of one overlapping bit triple {b[2i+1], b[2i], b[2i-1]}
  function automatic booth_dig_e booth_decode(input logic [2:0] trip);
    booth_dig_e d;
    unique case (trip)
      3'b000, 3'b111: d = DIG_ZERO;
      3'b001, 3'b010: d = DIG_P1;
      3'b011:         d = DIG_P2;
      3'b100:         d = DIG_M2;
      default:        d = DIG_M1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/smul_booth_row.sv
module smul_booth_row
  import smul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW    = 0,
  localparam int PW    = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] mcand,
  input  logic [2:0]        trip,
  output logic [PW-1:0]     row_pp
);

  booth_dig_e dig;
  logic [PW-1:0] mcand_ext;
  logic [PW-1:0] mag;
  logic [PW-1:0] signed_mag;

  assign dig       = booth_decode(trip);
  assign mcand_ext = {{DATA_W{mcand[DATA_W-1]}}, mcand};

  always_comb begin
    unique case (dig)
      DIG_P1, DIG_M1: mag = mcand_ext;
      DIG_P2, DIG_M2: mag = mcand_ext << 1;
      default:        mag = '0;
    endcase
  end

  always_comb begin
    if (dig == DIG_M1 || dig == DIG_M2) signed_mag = (~mag) + PW'(1);
    else                                signed_mag = mag;
  end

  assign row_pp = signed_mag << (2 * ROW);

endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int DATA_W = 16,
  localparam int PW    = 2 * DATA_W,
  localparam int ROWS  = DATA_W / 2
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  output logic [PW-1:0]           prod
);

  logic [ROWS:0][PW-1:0] chain;

  assign chain[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_add
    assign chain[r+1] = chain[r] + rows[r];
  end

  assign prod = chain[ROWS];

endmodule

// File: rtl/smul_flags.sv
module smul_flags
  import smul_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int PW    = 2 * DATA_W
) (
  input  logic [PW-1:0] prod,
  output cc_flags_t     cc
);

  logic [DATA_W:0] top_bits;
  logic            fits_short;

  // a value fits the short signed range when bits PW-1..DATA_W-1 all agree
  assign top_bits   = prod[PW-1:DATA_W-1];
  assign fits_short = (&top_bits) | ~(|top_bits);

  assign cc.n = prod[PW-1];
  assign cc.z = (prod == '0);
  assign cc.v = 1'b0;
  assign cc.c = ~fits_short;

endmodule

// File: rtl/smul_steer.sv
module smul_steer #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int PW    = 2 * DATA_W
) (
  input  logic              go,
  input  logic [IDX_W-1:0]  dst,
  input  logic [PW-1:0]     prod,
  output logic              hi_en,
  output logic [IDX_W-1:0]  hi_idx,
  output logic [DATA_W-1:0] hi_data,
  output logic              lo_en,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [DATA_W-1:0] lo_data
);

  logic dst_odd;

  assign dst_odd = dst[0];

  assign hi_idx  = dst;
  assign hi_data = prod[PW-1:DATA_W];
  assign hi_en   = go & ~dst_odd;

  assign lo_idx  = {dst[IDX_W-1:1], 1'b1};
  assign lo_data = prod[DATA_W-1:0];
  assign lo_en   = go;

endmodule

// File: rtl/smul_flags_unit.sv
module smul_flags_unit
  import smul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int PW    = 2 * DATA_W,
  localparam int ROWS  = DATA_W / 2
) (
  input  logic              mul_go,
  input  logic [DATA_W-1:0] src_reg,
  input  logic [DATA_W-1:0] src_opd,
  input  logic [IDX_W-1:0]  dst_idx,
  output logic              hi_wr_en,
  output logic [IDX_W-1:0]  hi_wr_idx,
  output logic [DATA_W-1:0] hi_wr_data,
  output logic              lo_wr_en,
  output logic [IDX_W-1:0]  lo_wr_idx,
  output logic [DATA_W-1:0] lo_wr_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  logic [DATA_W:0]         mult_ext;
  logic [ROWS-1:0][PW-1:0] pp_rows;
  logic [PW-1:0]           prod_w;
  cc_flags_t               cc_w;

  // multiplier with an implicit zero below bit 0 for the first triple
  assign mult_ext = {src_opd, 1'b0};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    smul_booth_row #(.DATA_W(DATA_W), .ROW(r)) u_row (
      .mcand  (src_reg),
      .trip   (mult_ext[2*r+2 -: 3]),
      .row_pp (pp_rows[r])
    );
  end

  smul_accum #(.DATA_W(DATA_W)) u_accum (
    .rows (pp_rows),
    .prod (prod_w)
  );

  smul_flags #(.DATA_W(DATA_W)) u_flags (
    .prod (prod_w),
    .cc   (cc_w)
  );

  smul_steer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_steer (
    .go      (mul_go),
    .dst     (dst_idx),
    .prod    (prod_w),
    .hi_en   (hi_wr_en),
    .hi_idx  (hi_wr_idx),
    .hi_data (hi_wr_data),
    .lo_en   (lo_wr_en),
    .lo_idx  (lo_wr_idx),
    .lo_data (lo_wr_data)
  );

  assign flag_n = cc_w.n;
  assign flag_z = cc_w.z;
  assign flag_v = cc_w.v;
  assign flag_c = cc_w.c;

endmodule

// File: rtl/smul_flags_unit_chk.sv
module smul_flags_unit_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int PW    = 2 * DATA_W
) (
  input logic              mul_go,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [PW-1:0]     prod_w,
  input logic              hi_wr_en,
  input logic [IDX_W-1:0]  hi_wr_idx,
  input logic [DATA_W-1:0] hi_wr_data,
  input logic              lo_wr_en,
  input logic [IDX_W-1:0]  lo_wr_idx,
  input logic [DATA_W-1:0] lo_wr_data,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c
);

  always_comb begin
    // R1: the two data ports together carry the accumulated product
    p_halves_join_r1: assert ({hi_wr_data, lo_wr_data} == prod_w)
      else $error("R1 halves do not rebuild product");
    // R2: a high-half write targets the destination index, which is even
    if (hi_wr_en) begin
      p_hi_even_r2: assert (hi_wr_idx == dst_idx && !dst_idx[0] && lo_wr_en)
        else $error("R2 high write misdirected");
    end
    // R3: the low-half target is always odd and shares the upper index bits
    p_lo_pair_r3: assert (lo_wr_idx[0] && lo_wr_idx[IDX_W-1:1] == dst_idx[IDX_W-1:1])
      else $error("R3 low index not pair partner");
    // R4: an odd destination gets only the low write, into itself
    if (mul_go && dst_idx[0]) begin
      p_odd_single_r4: assert (!hi_wr_en && lo_wr_en && lo_wr_idx == dst_idx)
        else $error("R4 odd destination writes wrong ports");
    end
    // R5: negative flag follows the sign of the high port
    p_sign_match_r5: assert (flag_n == hi_wr_data[DATA_W-1])
      else $error("R5 flag_n mismatch");
    // R6: zero flag iff both ports are zero
    p_zero_match_r6: assert (flag_z == (hi_wr_data == '0 && lo_wr_data == '0))
      else $error("R6 flag_z mismatch");
    // R8: carry iff high port is not a sign extension of the low port
    p_no_fit_r8: assert (flag_c == (hi_wr_data != {DATA_W{lo_wr_data[DATA_W-1]}}))
      else $error("R8 flag_c mismatch");
    // R9: no writes without issue
    if (!mul_go) begin
      p_idle_quiet_r9: assert (!hi_wr_en && !lo_wr_en)
        else $error("R9 write without issue");
    end
  end

endmodule

bind smul_flags_unit smul_flags_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .mul_go     (mul_go),
  .dst_idx    (dst_idx),
  .prod_w     (prod_w),
  .hi_wr_en   (hi_wr_en),
  .hi_wr_idx  (hi_wr_idx),
  .hi_wr_data (hi_wr_data),
  .lo_wr_en   (lo_wr_en),
  .lo_wr_idx  (lo_wr_idx),
  .lo_wr_data (lo_wr_data),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_c     (flag_c)
);

// File: tb/test_smul_flags_unit.sv
module test_smul_flags_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        mul_go;
  logic [15:0] src_reg;
  logic [15:0] src_opd;
  logic [2:0]  dst_idx;
  logic        hi_wr_en;
  logic [2:0]  hi_wr_idx;
  logic [15:0] hi_wr_data;
  logic        lo_wr_en;
  logic [2:0]  lo_wr_idx;
  logic [15:0] lo_wr_data;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  smul_flags_unit i_smul_flags_unit (
    .mul_go     (mul_go),
    .src_reg    (src_reg),
    .src_opd    (src_opd),
    .dst_idx    (dst_idx),
    .hi_wr_en   (hi_wr_en),
    .hi_wr_idx  (hi_wr_idx),
    .hi_wr_data (hi_wr_data),
    .lo_wr_en   (lo_wr_en),
    .lo_wr_idx  (lo_wr_idx),
    .lo_wr_data (lo_wr_data),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v),
    .flag_c     (flag_c)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (a=%0h b=%0h dst=%0d go=%0b)",
               req, what, act, exp, src_reg, src_opd, dst_idx, mul_go);
    end
  endtask

  // behavioural reference: integer multiply, then compare every output
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] d, input logic go);
    longint sa, sb, full;
    logic [31:0] p32;
    @(posedge clk);
    #1;
    src_reg = a; src_opd = b; dst_idx = d; mul_go = go;
    @(negedge clk);
    sa   = longint'($signed(a));
    sb   = longint'($signed(b));
    full = sa * sb;
    p32  = full[31:0];
    chk("R1", "hi_wr_data", hi_wr_data, p32[31:16]);
    chk("R1", "lo_wr_data", lo_wr_data, p32[15:0]);
    chk("R2", "hi_wr_idx",  hi_wr_idx, d);
    chk("R2", "hi_wr_en",   hi_wr_en, (go && (d % 2 == 0)) ? 1 : 0);
    chk("R3", "lo_wr_idx",  lo_wr_idx, d | 3'd1);
    chk("R3", "lo_wr_en",   lo_wr_en, go);
    chk("R5", "flag_n",     flag_n, (full < 0) ? 1 : 0);
    chk("R6", "flag_z",     flag_z, (full == 0) ? 1 : 0);
    chk("R7", "flag_v",     flag_v, 0);
    chk("R8", "flag_c",     flag_c, (full < -32768 || full > 32767) ? 1 : 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    mul_go = 1'b0; src_reg = '0; src_opd = '0; dst_idx = '0;
    // initial idle state: no writes (R9)
    @(negedge clk);
    chk("R9", "hi_wr_en idle", hi_wr_en, 0);
    chk("R9", "lo_wr_en idle", lo_wr_en, 0);

    apply(16'd3, 16'd4, 3'd2, 1'b1);          // R1 small positive
    apply(16'hFFFF, 16'hFFFF, 3'd0, 1'b1);    // R1 -1 * -1
    apply(16'd0, 16'h1234, 3'd4, 1'b1);       // R6 zero product
    apply(16'h8000, 16'h8000, 3'd4, 1'b1);    // R8 maxneg^2 = 0x40000000, C=1
    chk("R8", "maxneg^2 hi", hi_wr_data, 16'h4000);
    chk("R8", "maxneg^2 c", flag_c, 1);
    apply(16'h8000, 16'd1, 3'd2, 1'b1);       // R8 exactly -32768, C=0
    apply(16'h8000, 16'hFFFF, 3'd2, 1'b1);    // R8 +32768, C=1
    apply(16'h7FFF, 16'd1, 3'd0, 1'b1);       // R8 +32767, C=0
    apply(16'd181, 16'd181, 3'd0, 1'b1);      // R8 32761 fits
    apply(16'd182, 16'd181, 3'd0, 1'b1);      // R8 32942 overflows
    apply(16'hFF4B, 16'd181, 3'd6, 1'b1);     // R5 negative fits
    apply(16'd5, 16'hFFF9, 3'd7, 1'b1);       // R4 odd index 7
    chk("R4", "odd hi_wr_en", hi_wr_en, 0);
    chk("R4", "odd lo_wr_idx", lo_wr_idx, 3'd7);
    apply(16'd5, 16'hFFF9, 3'd6, 1'b1);       // R4 index 6 pairs with 7
    chk("R4", "even hi_wr_idx", hi_wr_idx, 3'd6);
    apply(16'h1234, 16'h5678, 3'd3, 1'b0);    // R9 no issue
    chk("R9", "lo_wr_en no go", lo_wr_en, 0);

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a    = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(a, lfsr, 3'(i % 8), (i % 5) != 0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule